// File: doc/BRIEF.md
# Prioritized Bidirectional GPIO Port

This block is an eight-pin general-purpose I/O port that sits on a simple register bus. It holds three registers: a direction register, an output latch and an analog-select register. Software sets each pin on its own as a driven output or as an undriven input. Software can also mark a pin as analog, which shuts off that pin's digital input path.

Several on-chip peripherals can claim pins by supplying an enable vector and a data vector. For each pin, a fixed-priority multiplexer hands control to the highest-priority peripheral that is enabled on it. The port latch, qualified by the direction bit, is used only when no peripheral claims the pin. A peripheral can drive a pin even while that pin is in analog mode.

Pin levels pass through a two-flop synchronizer and then through the analog gate. The result is read back at the port address. Reads at the latch address return the latch itself, so read-modify-write sequences never pick up pin levels.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads all ones (address 2), analog select reads all ones (address 3), the latch reads zero (address 1) and no pin has its output enable set.
- R2: A write strobe at address 0 or address 1 loads the latch with the write data on the next clock edge. Address 1 reads back the latch value, never the pin level.
- R3: Address 0 reads back the pin levels after a two-flop synchronizer. A change on a pin shows up after the second rising edge, and not after the first.
- R4: With no peripheral enabled on a pin, direction bit 0 enables that pin's output and drives the latch bit onto it. Direction bit 1 clears the pin's output enable.
- R5: A set analog-select bit (address 3, bit i for pin i) forces the synchronized digital input of pin i to 0. A cleared bit passes the pin level through.
- R6: Any peripheral enable on a pin sets that pin's output enable and drives the peripheral's data bit, whatever the direction bit and the latch hold.
- R7: When several sources are enabled on one pin, the source with the lowest index wins (source 0 is highest). The latch is always the lowest-priority source.
- R8: Analog select has no effect on the output path. Peripherals and the latch drive pins in analog mode exactly as they do in digital mode.
- R9: Each pin is arbitrated and configured independently of the others, so mixed per-pin patterns of direction and enables resolve bit by bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 2 | Register address: 0 port, 1 latch, 2 direction, 3 analog select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | 8 | Raw pin levels from the pads |
| src_oe | input | 24 | Peripheral output enables, 8 bits per source, source 0 in the low byte |
| src_dat | input | 24 | Peripheral output data, same layout as src_oe |
| pin_oe | output | 8 | Per-pin output enable to the pads |
| pin_out | output | 8 | Per-pin output data to the pads |
| pin_din | output | 8 | Synchronized, analog-gated digital input |

## Verification
The hardest case to reach is a single pin claimed by two or three peripherals at once while its neighbours are split between the latch and input mode. In that case one wrong priority index or a swapped bit lane shows up on only one bit. The vector table sets up overlapping enable masks with different data on each source, mixed direction nibbles, and the analog select left at its reset value. Every output bit is then resolved by a different rule. The synchronizer delay is checked on both sides of the second edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [1:0] {
        ADDR_PORT  = 2'd0,
        ADDR_LATCH = 2'd1,
        ADDR_DIR   = 2'd2,
        ADDR_ANSEL = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] lat_q,
    output logic [W-1:0] ansel_q
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] lat;
        logic [W-1:0] ansel;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            unique case (reg_addr_e'(addr))
                ADDR_PORT, ADDR_LATCH: st_d.lat   = wdata;
                ADDR_DIR:              st_d.dir   = wdata;
                ADDR_ANSEL:            st_d.ansel = wdata;
                default:               st_d       = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir   <= '1;
            st_q.lat   <= '0;
            st_q.ansel <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_q   = st_q.dir;
    assign lat_q   = st_q.lat;
    assign ansel_q = st_q.ansel;
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] ansel,
    output logic [W-1:0] din
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.meta   = pin_in;
        sy_d.stable = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign din = sy_q.stable & ~ansel;
endmodule

// File: rtl/gpio_port_prio.sv
module gpio_port_prio #(
    parameter int W = 8,
    parameter int N = 3
) (
    input  logic [N*W-1:0] src_oe,
    input  logic [N*W-1:0] src_dat,
    input  logic [W-1:0]   dir,
    input  logic [W-1:0]   lat,
    output logic [W-1:0]   pin_oe,
    output logic [W-1:0]   pin_out
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        always_comb begin
            pin_oe[p]  = ~dir[p];
            pin_out[p] = lat[p];
            for (int s = N - 1; s >= 0; s--) begin
                if (src_oe[s*W + p]) begin
                    pin_oe[p]  = 1'b1;
                    pin_out[p] = src_dat[s*W + p];
                end
            end
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W = 8,
    parameter int N = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [1:0]     bus_addr,
    input  logic [W-1:0]   bus_wdata,
    output logic [W-1:0]   bus_rdata,
    input  logic [W-1:0]   pin_in,
    input  logic [N*W-1:0] src_oe,
    input  logic [N*W-1:0] src_dat,
    output logic [W-1:0]   pin_oe,
    output logic [W-1:0]   pin_out,
    output logic [W-1:0]   pin_din
);
    logic [W-1:0] dir_q, lat_q, ansel_q;

    gpio_port_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .dir_q(dir_q), .lat_q(lat_q), .ansel_q(ansel_q)
    );

    gpio_port_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .ansel(ansel_q), .din(pin_din)
    );

    gpio_port_prio #(.W(W), .N(N)) u_prio (
        .src_oe(src_oe), .src_dat(src_dat), .dir(dir_q), .lat(lat_q),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            ADDR_PORT:  bus_rdata = pin_din;
            ADDR_LATCH: bus_rdata = lat_q;
            ADDR_DIR:   bus_rdata = dir_q;
            ADDR_ANSEL: bus_rdata = ansel_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W = 8,
    parameter int N = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic [1:0]     bus_addr,
    input logic [W-1:0]   bus_wdata,
    input logic [W-1:0]   bus_rdata,
    input logic [N*W-1:0] src_oe,
    input logic [N*W-1:0] src_dat,
    input logic [W-1:0]   pin_oe,
    input logic [W-1:0]   pin_out,
    input logic [W-1:0]   pin_din,
    input logic [W-1:0]   dir_q,
    input logic [W-1:0]   lat_q,
    input logic [W-1:0]   ansel_q
);
    logic [W-1:0] any_en;
    always_comb begin
        any_en = '0;
        for (int s = 0; s < N; s++) any_en |= src_oe[s*W +: W];
    end

    // R2: port or latch address write loads the latch
    p_latch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_addr == 2'd0 || bus_addr == 2'd1) |=> lat_q == $past(bus_wdata));

    // R2: latch address reads the latch, not the pins
    p_latch_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 2'd1 |-> bus_rdata == lat_q);

    // R4: unclaimed pins follow direction and latch
    p_dir_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe ^ ~dir_q) & ~any_en) == '0 && ((pin_out ^ lat_q) & ~any_en) == '0);

    // R5: analog pins read digital zero
    p_ansel_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_din & ansel_q) == '0);

    // R6: any claimed pin is driven
    p_claim_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & any_en) == any_en);

    // R7: source 0 always wins where enabled
    p_top_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out ^ src_dat[W-1:0]) & src_oe[W-1:0]) == '0);

    // R1: registers come out of reset at their defaults
    p_reset_vals_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> dir_q == '1 && ansel_q == '1 && lat_q == '0);
endmodule

bind gpio_port gpio_port_chk #(.W(W), .N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_oe(src_oe),
    .src_dat(src_dat), .pin_oe(pin_oe), .pin_out(pin_out), .pin_din(pin_din),
    .dir_q(dir_q), .lat_q(lat_q), .ansel_q(ansel_q)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    localparam int W = 8;
    localparam int N = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [1:0]     bus_addr = 2'd0;
    logic [W-1:0]   bus_wdata = '0;
    logic [W-1:0]   bus_rdata;
    logic [W-1:0]   pin_in = '0;
    logic [N*W-1:0] src_oe = '0;
    logic [N*W-1:0] src_dat = '0;
    logic [W-1:0]   pin_oe, pin_out, pin_din;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port #(.W(W), .N(N)) u_gpio_port (.*);

    // fields: dir, lat, oe0, d0, oe1, d1, oe2, d2, exp_oe, exp_out
    localparam logic [79:0] VEC [6] = '{
        {8'h00, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hA5},
        {8'hFF, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hA5},
        {8'hF0, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h3C},
        {8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h55, 8'hFF, 8'h55},
        {8'h00, 8'hFF, 8'h0F, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hF0},
        {8'h0F, 8'hAA, 8'h80, 8'h80, 8'hC0, 8'h00, 8'h03, 8'h01, 8'hF3, 8'hA9}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [W-1:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd2, "R1 dir", 8'hFF);
        rd(2'd3, "R1 ansel", 8'hFF);
        rd(2'd1, "R1 latch", 8'h00);
        check("R1 pin_oe", pin_oe, 8'h00);

        // vector table: R4 R6 R7 R8 R9 (analog select still all ones)
        for (int i = 0; i < 6; i++) begin
            wr(2'd2, VEC[i][79:72]);
            wr(2'd1, VEC[i][71:64]);
            @(negedge clk);
            src_oe  = {VEC[i][31:24], VEC[i][47:40], VEC[i][63:56]};
            src_dat = {VEC[i][23:16], VEC[i][39:32], VEC[i][55:48]};
            #1;
            check($sformatf("R4/R6/R7/R8/R9 oe vec%0d", i), pin_oe, VEC[i][15:8]);
            check($sformatf("R4/R6/R7/R8/R9 out vec%0d", i), pin_out, VEC[i][7:0]);
        end
        @(negedge clk);
        src_oe = '0; src_dat = '0;

        // R2: port address write lands in latch, latch read ignores pins
        pin_in = 8'hFF;
        wr(2'd0, 8'h5A);
        rd(2'd1, "R2 latch via port write", 8'h5A);
        // R5: all analog -> digital input zero despite pins high
        repeat (2) @(negedge clk);
        rd(2'd0, "R5 analog gated read", 8'h00);
        wr(2'd3, 8'h0F);
        rd(2'd3, "R5 ansel readback", 8'h0F);
        #1 check("R5 partial gate din", pin_din, 8'hF0);

        // R3: two-edge synchronizer latency
        wr(2'd3, 8'h00);
        @(negedge clk);
        pin_in = 8'hA5;
        @(negedge clk);
        #1 check("R3 not after first edge", pin_din, 8'hFF);
        @(negedge clk);
        #1 check("R3 after second edge", pin_din, 8'hA5);
        rd(2'd0, "R3 port read pins", 8'hA5);
        rd(2'd1, "R2 latch unaffected by pins", 8'h5A);

        // R8: analog mode on all pins, latch still drives outputs
        wr(2'd3, 8'hFF);
        wr(2'd2, 8'h00);
        #1 check("R8 oe in analog", pin_oe, 8'hFF);
        check("R8 out in analog", pin_out, 8'h5A);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule